// File: doc/BRIEF.md
# Seeded Round-Word Sequence Generator

This block supplies one 32-bit pseudo-random word to each of the 64 rounds of a hashing datapath. It holds a 32-bit shift register that software or a key path fills with a secret non-zero seed through a load strobe. Each advance then moves the register forward by 32 single-bit shifts at once, inside one clock, so that no two round words share bits of the sequence.

The feedback is a single XOR over four register taps. Counted from 1 at the LSB, the taps are bits 32, 26, 17 and 12, and the most significant bit is always among them. This set is the mirror of the taps {32, 20, 15, 6}: each tap t other than 32 maps to 32 - t. The all-zero state would lock the register, so a zero seed is replaced by 1 and flagged. A 6-bit round index reports which round the current word belongs to. It runs from 0 to 63 and then holds until the next load.

Top module: `seqgen_top`

## Requirements
- R1: After reset, word_out is 0x00000001, round_idx is 0 and zero_seed_flag is 0.
- R2: One single-bit step shifts the register one place toward the MSB, and the new bit 0 is the XOR of bits 31, 25, 16 and 11 (bits 32, 26, 17 and 12 counted from 1). A word advance is exactly 32 such steps.
- R3: In the cycle after seed_load with a non-zero seed_in, word_out equals seed_in advanced by 32 steps, round_idx is 0 and zero_seed_flag is 0. This holds also when the load arrives in the middle of a run.
- R4: A load with seed_in equal to zero behaves as a load of the value 1. zero_seed_flag is 1 in the following cycle only, unless that next cycle also loads a zero seed.
- R5: With seed_load low, step_en high and round_idx below 63, the next cycle shows word_out advanced by 32 steps and round_idx increased by one.
- R6: With round_idx at 63, step_en has no effect. word_out and round_idx hold until the next load.
- R7: With seed_load and step_en both low, word_out and round_idx hold.
- R8: When seed_load and step_en are high together, the load wins.
- R9: word_out is never zero, and the 64 words of one run from a load to round 63 are all distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load strobe for seed_in; restarts the round count |
| seed_in | input | 32 | Secret seed value |
| step_en | input | 1 | Advance to the next round word |
| word_out | output | 32 | Current round word |
| round_idx | output | 6 | Round the current word belongs to (0 to 63) |
| zero_seed_flag | output | 1 | One-cycle pulse: the last load carried a zero seed |

## Verification
The bench loads single-bit seeds at every bit position. A wrong tap or a wrong shift direction makes the first word differ from the bench model in at least one of these cases. Full 64-round runs are checked word by word, and every word of a run is compared against every other. This catches a step count other than 32, which would make words overlap or repeat. Extra advances at round 63 catch a counter that wraps instead of holding. Loads that arrive mid-run, or at the same time as step_en, catch wrong priority. A zero seed must give the word built from the value 1 and a flag lasting exactly one cycle. A design that let zero through would freeze at zero, and a sticky flag would still be high one cycle later.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
   localparam int          DEF_WIDTH  = 32;
   localparam int          DEF_ROUNDS = 64;
   // taps at bits 32, 26, 17 and 12 counted from 1
   localparam logic [31:0] DEF_TAPS   = 32'h8201_0800;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_STEP = 2'd2
   } seq_op_e;
endpackage

// File: rtl/seqgen_burst.sv
// Combinational advance of a Fibonacci shift register by STEPS single shifts.
module seqgen_burst #(
   parameter int               WIDTH    = 32,
   parameter int               STEPS    = 32,
   parameter logic [WIDTH-1:0] TAP_MASK = '1
) (
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [STEPS:0][WIDTH-1:0] chain;

   assign chain[0] = din;

   for (genvar i = 0; i < STEPS; i++) begin : g_step
      assign chain[i+1] = {chain[i][WIDTH-2:0], ^(chain[i] & TAP_MASK)};
   end

   assign dout = chain[STEPS];
endmodule

// File: rtl/seqgen_seed_guard.sv
// Replaces a zero seed by the value 1 and reports the substitution.
module seqgen_seed_guard #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] seed_raw,
   output logic [WIDTH-1:0] seed_safe,
   output logic             seed_zero
);
   assign seed_zero = (seed_raw == '0);
   assign seed_safe = seed_zero ? WIDTH'(1) : seed_raw;
endmodule

// File: rtl/seqgen_round_ctr.sv
// Round index: cleared on load, counts up on advance, holds at the last round.
module seqgen_round_ctr #(
   parameter int  ROUNDS = 64,
   localparam int IDX_W  = $clog2(ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [IDX_W-1:0] idx,
   output logic             at_last
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

   assign at_last = (idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (clr)
         idx <= '0;
      else if (inc && !at_last)
         idx <= idx + 1'b1;
   end
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
   import seqgen_pkg::*;
#(
   parameter int               WIDTH    = DEF_WIDTH,
   parameter logic [WIDTH-1:0] TAP_MASK = DEF_TAPS,
   parameter int               ROUNDS   = DEF_ROUNDS,
   localparam int              IDX_W    = $clog2(ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_load,
   input  logic [WIDTH-1:0] seed_in,
   input  logic             step_en,
   output logic [WIDTH-1:0] word_out,
   output logic [IDX_W-1:0] round_idx,
   output logic             zero_seed_flag
);
   // configuration checks at elaboration
   if (WIDTH < 4) begin : g_bad_width
      $error("seqgen_top: WIDTH must be at least 4");
   end
   if (TAP_MASK[WIDTH-1] != 1'b1) begin : g_bad_taps
      $error("seqgen_top: MSB must be part of the feedback");
   end
   if ($countones(TAP_MASK) < 2) begin : g_few_taps
      $error("seqgen_top: feedback needs at least two taps");
   end
   if (ROUNDS < 2) begin : g_bad_rounds
      $error("seqgen_top: ROUNDS must be at least 2");
   end

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] seed_safe;
   logic             seed_zero;
   logic [WIDTH-1:0] burst_in;
   logic [WIDTH-1:0] burst_out;
   logic             at_last;
   logic             flag_q;
   seq_op_e          op;

   seqgen_seed_guard #(.WIDTH(WIDTH)) guard_i (
      .seed_raw  (seed_in),
      .seed_safe (seed_safe),
      .seed_zero (seed_zero)
   );

   always_comb begin
      if (seed_load)
         op = OP_LOAD;
      else if (step_en && !at_last)
         op = OP_STEP;
      else
         op = OP_HOLD;
   end

   assign burst_in = (op == OP_LOAD) ? seed_safe : state_q;

   seqgen_burst #(
      .WIDTH    (WIDTH),
      .STEPS    (WIDTH),
      .TAP_MASK (TAP_MASK)
   ) burst_i (
      .din  (burst_in),
      .dout (burst_out)
   );

   seqgen_round_ctr #(.ROUNDS(ROUNDS)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (op == OP_LOAD),
      .inc     (op == OP_STEP),
      .idx     (round_idx),
      .at_last (at_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WIDTH'(1);
         flag_q  <= 1'b0;
      end else begin
         flag_q <= (op == OP_LOAD) && seed_zero;
         if (op != OP_HOLD)
            state_q <= burst_out;
      end
   end

   assign word_out       = state_q;
   assign zero_seed_flag = flag_q;
endmodule

// File: rtl/seqgen_chk.sv
module seqgen_chk #(
   parameter int  WIDTH  = 32,
   parameter int  ROUNDS = 64,
   localparam int IDX_W  = $clog2(ROUNDS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             seed_load,
   input logic [WIDTH-1:0] seed_in,
   input logic             step_en,
   input logic [WIDTH-1:0] word_out,
   input logic [IDX_W-1:0] round_idx,
   input logic             zero_seed_flag
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

   // R4
   zero_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_seed_flag |-> ($past(seed_load) && ($past(seed_in) == '0)));

   // R3
   good_seed_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed_in != '0) |=> !zero_seed_flag);

   // R8
   load_clears_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (round_idx == '0));

   // R5
   step_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_load && step_en && round_idx != LAST)
         |=> (round_idx == IDX_W'($past(round_idx) + 1'b1)) && !$stable(word_out));

   // R6
   last_round_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_load && round_idx == LAST) |=> ($stable(word_out) && $stable(round_idx)));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_load && !step_en) |=> ($stable(word_out) && $stable(round_idx)));

   // R9
   never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_out != '0);
endmodule

bind seqgen_top seqgen_chk #(
   .WIDTH  (WIDTH),
   .ROUNDS (ROUNDS)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .seed_load      (seed_load),
   .seed_in        (seed_in),
   .step_en        (step_en),
   .word_out       (word_out),
   .round_idx      (round_idx),
   .zero_seed_flag (zero_seed_flag)
);

// File: tb/seqgen_top_tb_top.sv
module seqgen_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [31:0] seed_in = '0;
   logic        step_en = 1'b0;
   logic [31:0] word_out;
   logic [5:0]  round_idx;
   logic        zero_seed_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   seqgen_top dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .seed_load      (seed_load),
      .seed_in        (seed_in),
      .step_en        (step_en),
      .word_out       (word_out),
      .round_idx      (round_idx),
      .zero_seed_flag (zero_seed_flag)
   );

   // software model: taps at 0-based bits 31, 25, 16, 11
   function automatic logic [31:0] one_shift(input logic [31:0] s);
      logic fb;
      fb = s[31] ^ s[25] ^ s[16] ^ s[11];
      return {s[30:0], fb};
   endfunction

   function automatic logic [31:0] adv_word(input logic [31:0] s);
      logic [31:0] t;
      t = s;
      for (int k = 0; k < 32; k++) t = one_shift(t);
      return t;
   endfunction

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag, input logic [31:0] ew, input int er, input bit ef);
      chk(word_out == ew, {tag, " word"}, word_out, ew);
      chk(round_idx == 6'(er), {tag, " round"}, 32'(round_idx), 32'(er));
      chk(zero_seed_flag == ef, {tag, " flag"}, 32'(zero_seed_flag), 32'(ef));
   endtask

   task automatic do_load(input logic [31:0] s, input bit with_step);
      seed_load = 1'b1;
      seed_in   = s;
      step_en   = with_step;
      cyc();
      seed_load = 1'b0;
      step_en   = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'(0), 32'(1));
      finish_run();
   end

   initial begin
      logic [31:0] e;
      logic [31:0] run [64];
      bit distinct;
      bit nonzero;

      cyc();
      cyc();
      // R1: reset state
      check_state("R1 reset", 32'h1, 0, 1'b0);
      rst_n = 1'b1;
      cyc();
      check_state("R1 after release", 32'h1, 0, 1'b0);

      // R2: single-bit seeds at every position exercise every tap
      for (int k = 0; k < 32; k++) begin
         do_load(32'h1 << k, 1'b0);
         check_state("R2 single-bit seed", adv_word(32'h1 << k), 0, 1'b0);
      end

      // R3, R5, R9: full runs from several seeds
      foreach (run[i]) run[i] = '0;
      for (int s = 0; s < 4; s++) begin
         logic [31:0] sd;
         sd = (s == 0) ? 32'hDEAD_BEEF : (s == 1) ? 32'hFFFF_FFFF :
              (s == 2) ? 32'h8000_0000 : 32'h0000_0001;
         do_load(sd, 1'b0);
         e = adv_word(sd);
         check_state("R3 load", e, 0, 1'b0);
         run[0] = word_out;
         for (int r = 1; r < 64; r++) begin
            step_en = 1'b1;
            cyc();
            e = adv_word(e);
            check_state("R5 step", e, r, 1'b0);
            run[r] = word_out;
         end
         step_en = 1'b0;
         distinct = 1'b1;
         nonzero  = 1'b1;
         for (int a = 0; a < 64; a++) begin
            if (run[a] == '0) nonzero = 1'b0;
            for (int b = a + 1; b < 64; b++)
               if (run[a] == run[b]) distinct = 1'b0;
         end
         chk(distinct, "R9 distinct words", 32'(distinct), 32'(1));
         chk(nonzero, "R9 nonzero words", 32'(nonzero), 32'(1));

         // R6: advances at round 63 are ignored
         for (int x = 0; x < 3; x++) begin
            step_en = 1'b1;
            cyc();
            check_state("R6 hold at last", e, 63, 1'b0);
         end
         step_en = 1'b0;
      end

      // R7: idle holds
      do_load(32'h1234_5678, 1'b0);
      e = adv_word(32'h1234_5678);
      step_en = 1'b1;
      cyc();
      e = adv_word(e);
      step_en = 1'b0;
      for (int x = 0; x < 3; x++) begin
         cyc();
         check_state("R7 idle", e, 1, 1'b0);
      end

      // R3: load in the middle of a run
      step_en = 1'b1;
      for (int x = 0; x < 10; x++) cyc();
      do_load(32'h0F0F_00F0, 1'b0);
      check_state("R3 mid-run load", adv_word(32'h0F0F_00F0), 0, 1'b0);

      // R8: load and step together
      step_en = 1'b1;
      for (int x = 0; x < 5; x++) cyc();
      do_load(32'hA5A5_5A5A, 1'b1);
      check_state("R8 load priority", adv_word(32'hA5A5_5A5A), 0, 1'b0);

      // R4: zero seed becomes 1, flag for one cycle
      do_load(32'h0, 1'b0);
      e = adv_word(32'h1);
      check_state("R4 zero seed", e, 0, 1'b1);
      cyc();
      check_state("R4 flag drops", e, 0, 1'b0);
      step_en = 1'b1;
      cyc();
      step_en = 1'b0;
      check_state("R4 recovers", adv_word(e), 1, 1'b0);

      // R4: zero seed loaded together with step_en
      do_load(32'h0, 1'b1);
      check_state("R4 zero seed with step", e, 0, 1'b1);
      do_load(32'h0000_0003, 1'b0);
      check_state("R4 good seed clears flag", adv_word(32'h3), 0, 1'b0);

      finish_run();
   end
endmodule